// File: doc/BRIEF.md
# Task Context Switch Sequencer

This block carries out a hardware switch between two execution contexts whose register images live in task records in memory. A core asserts a one-cycle request with the selector of the task it wants to enter. The sequencer writes the live context, word by word, into the record of the task now running. It then puts the new selector into the task register and fetches the new task's descriptor from the global descriptor table. From that descriptor it takes the base of the new record and reads the context back one word at a time. Each word read is handed to the core as a load strobe. A done pulse tells the core that it may resume.

The core provides its live context as a flat vector that stays stable while the sequencer is busy. A record is a run of 32-bit words, one per register, at base + 4·k. Word order is: general registers at k = 0..7, segment selectors at k = 8..13, local-table selector at 14, page-table base at 15, flags at 16 and instruction pointer at 17. Words 18..23 hold the stack selector and pointer for three privilege levels. The switch does not touch them. All memory traffic goes through a single request/ready port that moves one word per transaction.

Top module: `task_switch_seq`

## Requirements
- R1: After reset, busy_o, done_o, fault_o, mem_req_o and ld_valid_o are low, tr_sel_o is 0 and tr_base_o equals the RESET_BASE parameter.
- R2: An accepted switch first issues 18 writes, for k = 0..17 in ascending order, to tr_base_o + 4·k. Each write carries context word k, which is ctx_i[32k+31:32k]. No read comes before the last of these writes.
- R3: After the last save write completes, tr_sel_o takes the new selector. It holds that value when the first descriptor read is issued.
- R4: The descriptor sits at gdt_base_i + 8·index, where index is selector bits [15:3]. Selector bits [2:0] do not affect the address. The sequencer reads the lower word, which is the new record base, and then the word at +4. Bits [11:8] of that second word must equal the task-record type code 4'h9.
- R5: On a valid descriptor, 18 reads follow at new_base + 4·k for k = 0..17 in ascending order. Each completed read produces one ld_valid_o cycle, one cycle after its ready, with ld_idx_o = k and ld_data_o = the word read.
- R6: busy_o is high from the cycle after an accepted request. It falls in the cycle where done_o pulses for one cycle. That cycle comes one cycle after the last load strobe, and from then on tr_base_o equals the new record base.
- R7: While mem_req_o is high and mem_rdy_i is low, the address, write flag and write data hold steady. Each ready cycle completes exactly one word.
- R8: A request whose selector index is 0 gives a one-cycle fault_o in the next cycle. It causes no memory access and no busy. tr_sel_o and tr_base_o stay unchanged.
- R9: A descriptor with a wrong type code ends the switch with a one-cycle fault_o after the descriptor's second read. No load strobe occurs, tr_sel_o returns to the selector that was current before the request, and tr_base_o stays unchanged.
- R10: A request raised while busy_o is high has no effect on the switch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 1 | One-cycle switch request |
| sw_sel_i | input | 16 | Selector of the task to enter |
| gdt_base_i | input | 32 | Base address of the global descriptor table |
| ctx_i | input | 576 | Live context, word k at bits [32k+31:32k] |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdy_i | input | 1 | Memory ready; completes the current word |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| ld_valid_o | output | 1 | Context word load strobe |
| ld_idx_o | output | 5 | Index of the context word being loaded |
| ld_data_o | output | 32 | Context word value to load |
| tr_sel_o | output | 16 | Task register selector |
| tr_base_o | output | 32 | Record base of the current task |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle pulse: the new task may resume |
| fault_o | output | 1 | One-cycle pulse: the switch was refused |

## Verification
The bench counts cycles from the clock edge that accepts a request. busy_o and, for a null selector, fault_o are due one cycle later. The task register changes one cycle after the ready of the last save. A load strobe is due one cycle after each read's ready, and done_o one cycle after the final strobe. All outputs are sampled on the falling edge, so a value registered at a rising edge is read half a period later. The memory model logs, at the same falling edge where it raises ready, which transaction it expects next. The load monitor keeps the cycle number of the last strobe, so the done pulse is checked against that exact cycle and not against a wait window.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_TRLD,
    ST_DLO,
    ST_DHI,
    ST_REST,
    ST_RESUME
  } tsw_state_e;

  localparam int unsigned TSS_TYPE_LSB = 8;
  localparam int unsigned TSS_TYPE_W   = 4;
endpackage

// File: rtl/tsw_word_sel.sv
module tsw_word_sel #(
  parameter int unsigned DW    = 32,
  parameter int unsigned N     = 18,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N*DW-1:0]  ctx_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [DW-1:0]    word_o
);
  logic [DW-1:0] words [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign words[g] = ctx_i[g*DW +: DW];
  end

  always_comb begin
    word_o = '0;
    if (idx_i < IDX_W'(N)) word_o = words[idx_i];
  end
endmodule

// File: rtl/tsw_desc_dec.sv
module tsw_desc_dec
  import tsw_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned SEL_W    = 16,
  parameter logic [TSS_TYPE_W-1:0] TSS_TYPE = 4'h9
) (
  input  logic [AW-1:0]         gdt_base_i,
  input  logic [SEL_W-4:0]      sel_idx_i,
  input  logic [TSS_TYPE_W-1:0] type_i,
  output logic [AW-1:0]         desc_lo_addr_o,
  output logic [AW-1:0]         desc_hi_addr_o,
  output logic                  type_ok_o
);
  // 8-byte descriptor slots
  assign desc_lo_addr_o = gdt_base_i + {{(AW-SEL_W){1'b0}}, sel_idx_i, 3'b000};
  assign desc_hi_addr_o = desc_lo_addr_o + AW'(4);
  assign type_ok_o      = (type_i == TSS_TYPE);
endmodule

// File: rtl/tsw_fsm.sv
module tsw_fsm
  import tsw_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned CTX_WORDS  = 18,
  parameter logic [AW-1:0] RESET_BASE = '0,
  localparam int unsigned IDX_W     = $clog2(CTX_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_req_i,
  input  logic [SEL_W-1:0] sw_sel_i,
  input  logic [AW-1:0]    desc_lo_addr_i,
  input  logic [AW-1:0]    desc_hi_addr_i,
  input  logic             type_ok_i,
  input  logic             mem_rdy_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [SEL_W-1:0] new_sel_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             ld_valid_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic [DW-1:0]    ld_data_o,
  output logic [SEL_W-1:0] tr_sel_o,
  output logic [AW-1:0]    tr_base_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CTX_WORDS - 1);

  tsw_state_e       state_q;
  logic [IDX_W-1:0] cnt_q;
  logic [SEL_W-1:0] new_sel_q, old_sel_q, tr_sel_q;
  logic [AW-1:0]    tr_base_q, new_base_q, word_off;
  logic             done_q, fault_q, ld_valid_q;
  logic [IDX_W-1:0] ld_idx_q;
  logic [DW-1:0]    ld_data_q;

  assign word_off = {{(AW-IDX_W-2){1'b0}}, cnt_q, 2'b00};

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      ST_SAVE: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = tr_base_q + word_off;
      end
      ST_DLO: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_lo_addr_i;
      end
      ST_DHI: begin
        mem_req_o  = 1'b1;
        mem_addr_o = desc_hi_addr_i;
      end
      ST_REST: begin
        mem_req_o  = 1'b1;
        mem_addr_o = new_base_q + word_off;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      new_sel_q  <= '0;
      old_sel_q  <= '0;
      tr_sel_q   <= '0;
      tr_base_q  <= RESET_BASE;
      new_base_q <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      ld_valid_q <= 1'b0;
      ld_idx_q   <= '0;
      ld_data_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      ld_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (sw_req_i) begin
          if (sw_sel_i[SEL_W-1:3] == '0) begin
            fault_q <= 1'b1;  // null selector: refuse before any traffic
          end else begin
            new_sel_q <= sw_sel_i;
            old_sel_q <= tr_sel_q;
            cnt_q     <= '0;
            state_q   <= ST_SAVE;
          end
        end
        ST_SAVE: if (mem_rdy_i) begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            state_q <= ST_TRLD;
          end else begin
            cnt_q <= cnt_q + IDX_W'(1);
          end
        end
        ST_TRLD: begin
          tr_sel_q <= new_sel_q;
          state_q  <= ST_DLO;
        end
        ST_DLO: if (mem_rdy_i) begin
          new_base_q <= mem_rdata_i;
          state_q    <= ST_DHI;
        end
        ST_DHI: if (mem_rdy_i) begin
          if (type_ok_i) begin
            state_q <= ST_REST;
          end else begin
            tr_sel_q <= old_sel_q;  // undo task register load
            fault_q  <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_REST: if (mem_rdy_i) begin
          ld_valid_q <= 1'b1;
          ld_idx_q   <= cnt_q;
          ld_data_q  <= mem_rdata_i;
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            state_q <= ST_RESUME;
          end else begin
            cnt_q <= cnt_q + IDX_W'(1);
          end
        end
        ST_RESUME: begin
          tr_base_q <= new_base_q;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign new_sel_o  = new_sel_q;
  assign cnt_o      = cnt_q;
  assign ld_valid_o = ld_valid_q;
  assign ld_idx_o   = ld_idx_q;
  assign ld_data_o  = ld_data_q;
  assign tr_sel_o   = tr_sel_q;
  assign tr_base_o  = tr_base_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
endmodule

// File: rtl/task_switch_seq.sv
module task_switch_seq
  import tsw_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned N_GPR   = 8,
  parameter int unsigned N_SEG   = 6,
  parameter logic [AW-1:0] RESET_BASE = '0,
  parameter logic [TSS_TYPE_W-1:0] TSS_TYPE = 4'h9,
  localparam int unsigned CTX_WORDS = N_GPR + N_SEG + 4,
  localparam int unsigned IDX_W     = $clog2(CTX_WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sw_req_i,
  input  logic [SEL_W-1:0]        sw_sel_i,
  input  logic [AW-1:0]           gdt_base_i,
  input  logic [CTX_WORDS*DW-1:0] ctx_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [DW-1:0]           mem_wdata_o,
  input  logic                    mem_rdy_i,
  input  logic [DW-1:0]           mem_rdata_i,
  output logic                    ld_valid_o,
  output logic [IDX_W-1:0]        ld_idx_o,
  output logic [DW-1:0]           ld_data_o,
  output logic [SEL_W-1:0]        tr_sel_o,
  output logic [AW-1:0]           tr_base_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    fault_o
);
  logic [SEL_W-1:0] new_sel;
  logic [IDX_W-1:0] cnt;
  logic [AW-1:0]    desc_lo_addr, desc_hi_addr;
  logic             type_ok;

  tsw_word_sel #(.DW(DW), .N(CTX_WORDS), .IDX_W(IDX_W)) i_word_sel (
    .ctx_i  (ctx_i),
    .idx_i  (cnt),
    .word_o (mem_wdata_o)
  );

  tsw_desc_dec #(.AW(AW), .SEL_W(SEL_W), .TSS_TYPE(TSS_TYPE)) i_desc_dec (
    .gdt_base_i     (gdt_base_i),
    .sel_idx_i      (new_sel[SEL_W-1:3]),
    .type_i         (mem_rdata_i[TSS_TYPE_LSB +: TSS_TYPE_W]),
    .desc_lo_addr_o (desc_lo_addr),
    .desc_hi_addr_o (desc_hi_addr),
    .type_ok_o      (type_ok)
  );

  tsw_fsm #(
    .AW(AW), .DW(DW), .SEL_W(SEL_W), .CTX_WORDS(CTX_WORDS), .RESET_BASE(RESET_BASE)
  ) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sw_req_i       (sw_req_i),
    .sw_sel_i       (sw_sel_i),
    .desc_lo_addr_i (desc_lo_addr),
    .desc_hi_addr_i (desc_hi_addr),
    .type_ok_i      (type_ok),
    .mem_rdy_i      (mem_rdy_i),
    .mem_rdata_i    (mem_rdata_i),
    .new_sel_o      (new_sel),
    .cnt_o          (cnt),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .ld_valid_o     (ld_valid_o),
    .ld_idx_o       (ld_idx_o),
    .ld_data_o      (ld_data_o),
    .tr_sel_o       (tr_sel_o),
    .tr_base_o      (tr_base_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .fault_o        (fault_o)
  );
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned SEL_W     = 16,
  parameter int unsigned CTX_WORDS = 18,
  localparam int unsigned IDX_W    = $clog2(CTX_WORDS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             mem_rdy_i,
  input logic             ld_valid_o,
  input logic [IDX_W-1:0] ld_idx_o,
  input logic [SEL_W-1:0] tr_sel_o,
  input logic [AW-1:0]    tr_base_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !ld_valid_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o || fault_o);

  p_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  p_fault_no_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !ld_valid_o);

  p_ld_idx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> ld_idx_o < IDX_W'(CTX_WORDS));

  p_tr_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && $past(!busy_o) |-> $stable(tr_sel_o) && $stable(tr_base_o));
endmodule

bind task_switch_seq tsw_checker #(
  .AW(AW), .DW(DW), .SEL_W(SEL_W), .CTX_WORDS(CTX_WORDS)
) i_tsw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdy_i   (mem_rdy_i),
  .ld_valid_o  (ld_valid_o),
  .ld_idx_o    (ld_idx_o),
  .tr_sel_o    (tr_sel_o),
  .tr_base_o   (tr_base_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/test_task_switch_seq.sv
module test_task_switch_seq;
  localparam int NW = 18;
  localparam logic [31:0] RBASE = 32'h200;
  localparam logic [31:0] GDT   = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_req = 1'b0;
  logic [15:0] sw_sel = '0;
  logic [NW*32-1:0] ctx = '0;
  logic mem_req, mem_we, mem_rdy = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic ld_valid;
  logic [4:0] ld_idx;
  logic [31:0] ld_data, tr_base;
  logic [15:0] tr_sel;
  logic busy, done, fault;

  always #5 clk = ~clk;

  task_switch_seq #(.RESET_BASE(RBASE)) i_task_switch_seq (
    .clk_i(clk), .rst_ni(rst_n), .sw_req_i(sw_req), .sw_sel_i(sw_sel),
    .gdt_base_i(GDT), .ctx_i(ctx),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .mem_rdata_i(mem_rdata),
    .ld_valid_o(ld_valid), .ld_idx_o(ld_idx), .ld_data_o(ld_data),
    .tr_sel_o(tr_sel), .tr_base_o(tr_base),
    .busy_o(busy), .done_o(done), .fault_o(fault)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [256];

  // scoreboard queues
  logic        q_we [$];
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  bit          q_trchk [$];
  string       q_tag [$];
  logic [4:0]  l_idx [$];
  logic [31:0] l_data [$];

  int cyc = 0, last_ld_cyc = -10, lat = 0, wait_n = 0;
  bit held = 0;
  logic [31:0] held_addr = '0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor + memory model, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_sim();
    end
    if (ld_valid) begin
      if (l_idx.size() == 0) check("R5 unexpected load", 32'(ld_idx), 32'hFFFF_FFFF);
      else begin
        check("R5 load idx", 32'(ld_idx), 32'(l_idx.pop_front()));
        check("R5 load data", ld_data, l_data.pop_front());
      end
      last_ld_cyc = cyc;
    end
    if (done) check("R6 done one cycle after last load", 32'(cyc), 32'(last_ld_cyc + 1));
    if (mem_req) begin
      if (held) check("R7 address held while stalled", mem_addr, held_addr);
      if (lat == 0) begin
        mem_rdy = 1'b1;
        if (q_we.size() == 0) check("R2 unexpected memory access", mem_addr, 32'hFFFF_FFFF);
        else begin
          string tg;
          logic [31:0] ed;
          bit tc;
          tg = q_tag.pop_front();
          ed = q_data.pop_front();
          tc = q_trchk.pop_front();
          check({tg, " write flag"}, 32'(mem_we), 32'(q_we.pop_front()));
          check({tg, " address"}, mem_addr, q_addr.pop_front());
          if (mem_we) check({tg, " write data"}, mem_wdata, ed);
          if (tc) check("R3 task register at descriptor read", 32'(tr_sel), ed);
        end
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:2]];
        held = 0;
        lat = wait_n;
      end else begin
        mem_rdy = 1'b0;
        lat--;
        held = 1;
        held_addr = mem_addr;
      end
    end else begin
      mem_rdy = 1'b0;
      held = 0;
    end
  end

  logic [15:0] cur_sel = '0;
  logic [31:0] cur_base = RBASE;

  task automatic run_switch(input logic [15:0] sel, input logic [31:0] nbase,
                            input logic [3:0] typ, input bit inject);
    bit ok;
    logic [31:0] daddr;
    int t;
    ok = (typ == 4'h9);
    daddr = GDT + {16'h0, sel[15:3], 3'b000};
    mem[daddr[9:2]]     = nbase;
    mem[daddr[9:2] + 1] = {20'h0, typ, 8'h0};
    for (int k = 0; k < NW; k++) begin
      ctx[k*32 +: 32] = {sel ^ 16'hC3C3, 8'(k), 8'h5A};
      mem[nbase[9:2] + 8'(k)] = nbase ^ {4'hA, 8'(k), 20'h0_0F0F};
    end
    for (int k = 0; k < NW; k++) begin
      q_we.push_back(1'b1); q_addr.push_back(cur_base + 32'(4*k));
      q_data.push_back(ctx[k*32 +: 32]); q_trchk.push_back(1'b0); q_tag.push_back("R2 save");
    end
    q_we.push_back(1'b0); q_addr.push_back(daddr); q_data.push_back({16'h0, sel});
    q_trchk.push_back(1'b1); q_tag.push_back("R4 descriptor low");
    q_we.push_back(1'b0); q_addr.push_back(daddr + 32'd4); q_data.push_back('0);
    q_trchk.push_back(1'b0); q_tag.push_back("R4 descriptor high");
    if (ok) for (int k = 0; k < NW; k++) begin
      q_we.push_back(1'b0); q_addr.push_back(nbase + 32'(4*k)); q_data.push_back('0);
      q_trchk.push_back(1'b0); q_tag.push_back("R5 restore");
      l_idx.push_back(5'(k)); l_data.push_back(nbase ^ {4'hA, 8'(k), 20'h0_0F0F});
    end
    @(negedge clk); sw_req = 1'b1; sw_sel = sel;
    @(negedge clk); sw_req = 1'b0;
    check("R6 busy after request", 32'(busy), 32'd1);
    if (inject) begin
      repeat (3) @(negedge clk);
      sw_req = 1'b1; sw_sel = 16'h0028;  // R10: ignored while busy
      @(negedge clk); sw_req = 1'b0;
    end
    t = 0;
    while (!(done || fault) && t < 3000) begin @(negedge clk); t++; end
    check("R6 switch finished in time", 32'(t < 3000), 32'd1);
    if (ok) begin
      check("R6 done", 32'(done), 32'd1);
      check("R6 busy low at done", 32'(busy), 32'd0);
      check("R3 task register selector", 32'(tr_sel), 32'(sel));
      check("R6 task base", tr_base, nbase);
      check("R5 all loads delivered", 32'(l_idx.size()), 32'd0);
      cur_sel = sel; cur_base = nbase;
    end else begin
      check("R9 fault", 32'(fault), 32'd1);
      check("R9 task register reverted", 32'(tr_sel), 32'(cur_sel));
      check("R9 task base unchanged", tr_base, cur_base);
    end
    check("R2 all transactions seen", 32'(q_we.size()), 32'd0);
    if (inject) begin
      repeat (4) @(negedge clk);
      check("R10 no second switch", 32'(busy), 32'd0);
      check("R10 selector kept", 32'(tr_sel), 32'(sel));
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 fault", 32'(fault), 32'd0);
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 ld_valid", 32'(ld_valid), 32'd0);
    check("R1 tr_sel", 32'(tr_sel), 32'd0);
    check("R1 tr_base", tr_base, RBASE);
    rst_n = 1'b1;
    @(negedge clk);

    wait_n = 0; run_switch(16'h0008, 32'h280, 4'h9, 0);
    wait_n = 2; run_switch(16'h0013, 32'h300, 4'h9, 0);  // R4: low bits ignored

    // R8: null selector
    @(negedge clk); sw_req = 1'b1; sw_sel = 16'h0004;
    @(negedge clk); sw_req = 1'b0;
    check("R8 fault pulse", 32'(fault), 32'd1);
    check("R8 no busy", 32'(busy), 32'd0);
    check("R8 no memory request", 32'(mem_req), 32'd0);
    @(negedge clk);
    check("R8 fault one cycle", 32'(fault), 32'd0);
    check("R8 selector unchanged", 32'(tr_sel), 32'(cur_sel));
    check("R8 base unchanged", tr_base, cur_base);

    wait_n = 1; run_switch(16'h0018, 32'h380, 4'h2, 0);  // R9
    wait_n = 1; run_switch(16'h0020, 32'h200, 4'h9, 1);  // R10
    wait_n = 0; run_switch(16'h0018, 32'h380, 4'h9, 0);

    finish_sim();
  end
endmodule